// File: doc/BRIEF.md
# Bunch-Crossing and Event Tagger

This block runs on the bunch clock. It keeps two counters. The first is a crossing counter that steps once per clock. The second is an event counter that steps once for each positive trigger decision. On every accept, the block issues the current pair of counter values as a tag. It raises a one-cycle valid strobe with the tag and also provides a full-width extension of the event number.

Two reset pulses arrive with a fixed offset from the data they must line up with. The periodic bunch reset clears the crossing counter, and the event reset clears the event counter. Each pulse passes through its own delay line, which can be set from 0 to 255 cycles. This lets the counters read correctly at a chosen point further down the data path.

The block also checks downstream fragments for consistency. Each issued tag waits in a small in-order queue until a fragment comes back. A returning fragment's pair is compared with the oldest waiting tag. A mismatch, a fragment with nothing to compare against, or an issued tag that does not fit in the queue counts as an error. Errors set a sticky flag and advance a saturating counter. A clear input resets both the flag and the counter.

Top module: `xing_evt_tagger`

## Requirements
- R1: While no delayed bunch reset is active, the crossing counter increments by one each clock. The cycle after it equals `bx_last_i`, it reads 0 (3563 gives a 3564-crossing period).
- R2: A bunch-reset pulse sampled at clock edge n makes the crossing counter read 0 after edge n+`bx_dly_i`, for delays 0 to 255.
- R3: The event counter changes only on an accepted trigger. The tag issued for an accept carries the crossing count and the event count from before that edge's increment.
- R4: An event-reset pulse sampled at edge n clears the event counter at edge n+`ev_dly_i`. If an accept lands on the clearing edge, its tag keeps the old value and the counter reads 0 afterwards.
- R5: `tag_valid_o` is high for exactly the cycle after each edge where `accept_i` was sampled high. Outside those cycles, the tag outputs hold their last values.
- R6: `tag_ev_o` always equals the low EV_W bits of the 32-bit `tag_ev_ext_o`. The extension counts the same accepts and clears on the same reset.
- R7: A fragment (`frag_valid_i`) is compared with the oldest tag not yet matched and removes it. A differing pair, or a fragment that arrives when no tag is waiting, is an error.
- R8: An accept that finds DEPTH tags waiting, with no fragment in the same cycle, is an error, and its tag is not queued.
- R9: `err_flag_o` stays set until `err_clr_i`. The clear resets both flag and counter, but an error in the same cycle wins (the flag reads 1 and the count reads 1).
- R10: `err_count_o` advances by one per cycle with any error and holds at all ones.
- R11: While `rst_n` is low, all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released in step with clk |
| bunch_rst_i | input | 1 | Periodic bunch-reset pulse |
| event_rst_i | input | 1 | Event-reset pulse |
| accept_i | input | 1 | Trigger accept strobe for this crossing |
| bx_dly_i | input | DLY_W | Delay applied to the bunch reset, in cycles |
| ev_dly_i | input | DLY_W | Delay applied to the event reset, in cycles |
| bx_last_i | input | BX_W | Highest crossing count before wrap |
| frag_valid_i | input | 1 | Returning fragment present |
| frag_bx_i | input | BX_W | Crossing number carried by the fragment |
| frag_ev_i | input | EV_W | Event number carried by the fragment |
| err_clr_i | input | 1 | Clears error flag and counter |
| tag_valid_o | output | 1 | Tag strobe |
| tag_bx_o | output | BX_W | Tagged crossing number |
| tag_ev_o | output | EV_W | Tagged local event number |
| tag_ev_ext_o | output | EXT_W | Tagged 32-bit event number |
| err_flag_o | output | 1 | Sticky consistency error |
| err_count_o | output | ERR_W | Saturating error count |

## Verification
The bench builds the block with EV_W=4, DEPTH=4 and ERR_W=4, keeping BX_W=12 and DLY_W=8. With these values, the local event number wraps every 16 accepts, the tag queue overflows under short accept bursts, and the error counter saturates after 15 errors. The default 3564-crossing wrap is still exercised in one long stretch without resets. A shortened period is then used together with reset delays of 0, 1, 7 and 255.

// File: rtl/tgr_pkg.sv
package tgr_pkg;
  localparam int unsigned TGR_BX_W    = 12;
  localparam int unsigned TGR_EV_W    = 8;
  localparam int unsigned TGR_EXT_W   = 32;
  localparam int unsigned TGR_DLY_W   = 8;
  localparam int unsigned TGR_DEPTH   = 16;
  localparam int unsigned TGR_ERR_W   = 16;
  localparam int unsigned TGR_BX_LAST = 3563;

  // index of each reset channel inside the aligner bank
  typedef enum logic {
    RST_CH_BX = 1'b0,
    RST_CH_EV = 1'b1
  } rst_ch_e;
endpackage

// File: rtl/tgr_pulse_delay.sv
module tgr_pulse_delay #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             pulse_o
);
  localparam int unsigned TAPS = (1 << DLY_W) - 1;

  logic [TAPS-1:0]  line_q;
  logic [TAPS-1:0]  line_d;
  logic [DLY_W-1:0] tap_sel;

  // line_q[k] holds the input sampled k+1 edges ago
  always_comb begin
    line_d  = {line_q[TAPS-2:0], pulse_i};
    tap_sel = dly_i - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  always_comb begin
    if (dly_i == '0) pulse_o = pulse_i;
    else             pulse_o = line_q[tap_sel];
  end
endmodule

// File: rtl/tgr_bx_counter.sv
module tgr_bx_counter #(
  parameter int unsigned BX_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic [BX_W-1:0] last_i,
  output logic [BX_W-1:0] cnt_o
);
  logic [BX_W-1:0] cnt_q;
  logic [BX_W-1:0] cnt_d;

  always_comb begin
    if (clr_i)                cnt_d = '0;
    else if (cnt_q == last_i) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tgr_ev_counter.sv
module tgr_ev_counter #(
  parameter int unsigned BX_W  = 12,
  parameter int unsigned EXT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             clr_i,
  input  logic [BX_W-1:0]  bx_i,
  output logic [EXT_W-1:0] ev_o,
  output logic             tag_valid_o,
  output logic [BX_W-1:0]  tag_bx_o,
  output logic [EXT_W-1:0] tag_ev_o
);
  logic [EXT_W-1:0] ev_q, ev_d;
  logic             ev_en;
  logic             tv_q;
  logic [BX_W-1:0]  tbx_q;
  logic [EXT_W-1:0] tev_q;

  always_comb begin
    ev_en = accept_i | clr_i;
    if (clr_i) ev_d = '0;
    else       ev_d = ev_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ev_q <= '0;
    else if (ev_en) ev_q <= ev_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tv_q <= 1'b0;
    else        tv_q <= accept_i;
  end

  // tag capture uses the counter values present before this edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbx_q <= '0;
      tev_q <= '0;
    end else if (accept_i) begin
      tbx_q <= bx_i;
      tev_q <= ev_q;
    end
  end

  assign ev_o        = ev_q;
  assign tag_valid_o = tv_q;
  assign tag_bx_o    = tbx_q;
  assign tag_ev_o    = tev_q;
endmodule

// File: rtl/tgr_frag_check.sv
module tgr_frag_check #(
  parameter int unsigned BX_W  = 12,
  parameter int unsigned EV_W  = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [BX_W-1:0]  push_bx_i,
  input  logic [EV_W-1:0]  push_ev_i,
  input  logic             frag_valid_i,
  input  logic [BX_W-1:0]  frag_bx_i,
  input  logic [EV_W-1:0]  frag_ev_i,
  input  logic             err_clr_i,
  output logic             err_evt_o,
  output logic             err_flag_o,
  output logic [ERR_W-1:0] err_count_o
);
  localparam int unsigned PAIR_W = BX_W + EV_W;
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LVL_W  = PTR_W + 1;
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic [PAIR_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic              empty, full, pop, wr_en, mism, ovf;
  logic [PAIR_W-1:0] head, frag_pair, push_pair;
  logic              flag_q, flag_d;
  logic [ERR_W-1:0]  cnt_q, cnt_d, cnt_base;

  always_comb begin
    empty     = (lvl_q == '0);
    full      = (lvl_q == LVL_FULL);
    head      = mem_q[rd_q];
    frag_pair = {frag_bx_i, frag_ev_i};
    push_pair = {push_bx_i, push_ev_i};
    pop       = frag_valid_i & ~empty;
    mism      = frag_valid_i & (empty | (head != frag_pair));
    ovf       = push_i & full & ~pop;
    wr_en     = push_i & ~ovf;
  end

  always_comb begin
    rd_d  = pop   ? rd_q + 1'b1 : rd_q;
    wr_d  = wr_en ? wr_q + 1'b1 : wr_q;
    case ({wr_en, pop})
      2'b10:   lvl_d = lvl_q + 1'b1;
      2'b01:   lvl_d = lvl_q - 1'b1;
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      lvl_q <= lvl_d;
    end
  end

  // queue storage carries no reset; validity comes from lvl_q
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_q] <= push_pair;
  end

  always_comb begin
    err_evt_o = mism | ovf;
    flag_d    = (err_clr_i ? 1'b0 : flag_q) | err_evt_o;
    cnt_base  = err_clr_i ? '0 : cnt_q;
    if (err_evt_o && !(&cnt_base)) cnt_d = cnt_base + 1'b1;
    else                           cnt_d = cnt_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
    end
  end

  assign err_flag_o  = flag_q;
  assign err_count_o = cnt_q;
endmodule

// File: rtl/xing_evt_tagger.sv
module xing_evt_tagger
  import tgr_pkg::*;
#(
  parameter int unsigned BX_W  = TGR_BX_W,
  parameter int unsigned EV_W  = TGR_EV_W,
  parameter int unsigned EXT_W = TGR_EXT_W,
  parameter int unsigned DLY_W = TGR_DLY_W,
  parameter int unsigned DEPTH = TGR_DEPTH,
  parameter int unsigned ERR_W = TGR_ERR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bunch_rst_i,
  input  logic             event_rst_i,
  input  logic             accept_i,
  input  logic [DLY_W-1:0] bx_dly_i,
  input  logic [DLY_W-1:0] ev_dly_i,
  input  logic [BX_W-1:0]  bx_last_i,
  input  logic             frag_valid_i,
  input  logic [BX_W-1:0]  frag_bx_i,
  input  logic [EV_W-1:0]  frag_ev_i,
  input  logic             err_clr_i,
  output logic             tag_valid_o,
  output logic [BX_W-1:0]  tag_bx_o,
  output logic [EV_W-1:0]  tag_ev_o,
  output logic [EXT_W-1:0] tag_ev_ext_o,
  output logic             err_flag_o,
  output logic [ERR_W-1:0] err_count_o
);
  localparam int unsigned N_RST = 2;

  logic [N_RST-1:0] rst_raw;
  logic [N_RST-1:0] rst_algn;
  logic [DLY_W-1:0] rst_dly [N_RST];
  logic             bx_rst_d, ev_rst_d;
  logic [BX_W-1:0]  bx_cnt;
  logic [EXT_W-1:0] ev_ext;
  logic [EXT_W-1:0] tag_ext;
  logic             err_evt;

  always_comb begin
    rst_raw[RST_CH_BX] = bunch_rst_i;
    rst_raw[RST_CH_EV] = event_rst_i;
    rst_dly[RST_CH_BX] = bx_dly_i;
    rst_dly[RST_CH_EV] = ev_dly_i;
    bx_rst_d           = rst_algn[RST_CH_BX];
    ev_rst_d           = rst_algn[RST_CH_EV];
  end

  for (genvar g = 0; g < N_RST; g++) begin : g_algn
    tgr_pulse_delay #(.DLY_W(DLY_W)) u_dly (
      .clk     (clk),
      .rst_n   (rst_n),
      .pulse_i (rst_raw[g]),
      .dly_i   (rst_dly[g]),
      .pulse_o (rst_algn[g])
    );
  end

  tgr_bx_counter #(.BX_W(BX_W)) u_bx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (bx_rst_d),
    .last_i (bx_last_i),
    .cnt_o  (bx_cnt)
  );

  tgr_ev_counter #(.BX_W(BX_W), .EXT_W(EXT_W)) u_ev (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept_i),
    .clr_i       (ev_rst_d),
    .bx_i        (bx_cnt),
    .ev_o        (ev_ext),
    .tag_valid_o (tag_valid_o),
    .tag_bx_o    (tag_bx_o),
    .tag_ev_o    (tag_ext)
  );

  tgr_frag_check #(.BX_W(BX_W), .EV_W(EV_W), .DEPTH(DEPTH), .ERR_W(ERR_W)) u_chkq (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (accept_i),
    .push_bx_i    (bx_cnt),
    .push_ev_i    (ev_ext[EV_W-1:0]),
    .frag_valid_i (frag_valid_i),
    .frag_bx_i    (frag_bx_i),
    .frag_ev_i    (frag_ev_i),
    .err_clr_i    (err_clr_i),
    .err_evt_o    (err_evt),
    .err_flag_o   (err_flag_o),
    .err_count_o  (err_count_o)
  );

  assign tag_ev_ext_o = tag_ext;
  assign tag_ev_o     = tag_ext[EV_W-1:0];
endmodule

// File: rtl/xing_evt_tagger_chk.sv
module xing_evt_tagger_chk #(
  parameter int unsigned BX_W  = 12,
  parameter int unsigned EXT_W = 32,
  parameter int unsigned ERR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept_i,
  input logic             tag_valid_o,
  input logic [BX_W-1:0]  bx_cnt,
  input logic             bx_rst_d,
  input logic [BX_W-1:0]  bx_last_i,
  input logic [EXT_W-1:0] ev_ext,
  input logic             ev_rst_d,
  input logic             err_evt,
  input logic             err_clr_i,
  input logic             err_flag_o,
  input logic [ERR_W-1:0] err_count_o
);
  p_bx_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bx_rst_d && bx_cnt < bx_last_i) |=> bx_cnt == $past(bx_cnt) + 1'b1);

  p_bx_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bx_rst_d && bx_cnt == bx_last_i) |=> bx_cnt == '0);

  p_bx_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bx_rst_d |=> bx_cnt == '0);

  p_ev_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_i && !ev_rst_d) |=> $stable(ev_ext));

  p_ev_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rst_d |=> ev_ext == '0);

  p_tag_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> tag_valid_o);

  p_tag_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> !tag_valid_o);

  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err_flag_o);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag_o && !err_clr_i) |=> err_flag_o);

  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_i && !err_evt) |=> (!err_flag_o && err_count_o == '0));

  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (&err_count_o && !err_clr_i) |=> &err_count_o);
endmodule

bind xing_evt_tagger xing_evt_tagger_chk #(
  .BX_W(BX_W), .EXT_W(EXT_W), .ERR_W(ERR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept_i    (accept_i),
  .tag_valid_o (tag_valid_o),
  .bx_cnt      (bx_cnt),
  .bx_rst_d    (bx_rst_d),
  .bx_last_i   (bx_last_i),
  .ev_ext      (ev_ext),
  .ev_rst_d    (ev_rst_d),
  .err_evt     (err_evt),
  .err_clr_i   (err_clr_i),
  .err_flag_o  (err_flag_o),
  .err_count_o (err_count_o)
);

// File: tb/xing_evt_tagger_tb.sv
module xing_evt_tagger_tb;
  localparam int BX_W  = 12;
  localparam int EV_W  = 4;
  localparam int EXT_W = 32;
  localparam int DLY_W = 8;
  localparam int DEPTH = 4;
  localparam int ERR_W = 4;
  localparam int HL    = 1 << DLY_W;

  logic             clk, rst_n;
  logic             bcr, evr, acc, fv, eclr;
  logic [DLY_W-1:0] bdly, edly;
  logic [BX_W-1:0]  last, fbx;
  logic [EV_W-1:0]  fev;
  logic             tag_valid, err_flag;
  logic [BX_W-1:0]  tag_bx;
  logic [EV_W-1:0]  tag_ev;
  logic [EXT_W-1:0] tag_ext;
  logic [ERR_W-1:0] err_cnt;

  int n_chk = 0, n_fail = 0, wd = 0, cyc = 0;
  int p_acc = 0, p_frag = 0, p_bad = 0, p_clr = 0, bcr_per = 0, evr_per = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  xing_evt_tagger #(
    .BX_W(BX_W), .EV_W(EV_W), .EXT_W(EXT_W),
    .DLY_W(DLY_W), .DEPTH(DEPTH), .ERR_W(ERR_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bunch_rst_i(bcr), .event_rst_i(evr),
    .accept_i(acc), .bx_dly_i(bdly), .ev_dly_i(edly), .bx_last_i(last),
    .frag_valid_i(fv), .frag_bx_i(fbx), .frag_ev_i(fev), .err_clr_i(eclr),
    .tag_valid_o(tag_valid), .tag_bx_o(tag_bx), .tag_ev_o(tag_ev),
    .tag_ev_ext_o(tag_ext), .err_flag_o(err_flag), .err_count_o(err_cnt)
  );

  // reference model, built from the requirements
  logic [HL-1:0]    hb, he;
  logic [BX_W-1:0]  m_bx, m_tbx;
  logic [EXT_W-1:0] m_ev, m_tev;
  logic             m_tv, m_flag;
  logic [ERR_W-1:0] m_cnt;
  logic [BX_W-1:0]  q_bx [DEPTH];
  logic [EV_W-1:0]  q_ev [DEPTH];
  int               q_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb = '0; he = '0; m_bx = '0; m_tbx = '0; m_ev = '0; m_tev = '0;
      m_tv = 1'b0; m_flag = 1'b0; m_cnt = '0; q_n = 0;
    end else begin
      logic rb, re, mism, ovf, pop, err;
      hb = {hb[HL-2:0], bcr};
      he = {he[HL-2:0], evr};
      rb = hb[bdly];                       // R2 alignment
      re = he[edly];                       // R4 alignment
      m_tv = acc;                          // R5
      if (acc) begin m_tbx = m_bx; m_tev = m_ev; end   // R3 pre-increment
      mism = fv && (q_n == 0 || q_bx[0] != fbx || q_ev[0] != fev);   // R7
      pop  = fv && q_n > 0;
      ovf  = acc && q_n == DEPTH && !pop;                            // R8
      if (pop) begin
        for (int k = 0; k < DEPTH - 1; k++) begin q_bx[k] = q_bx[k+1]; q_ev[k] = q_ev[k+1]; end
        q_n--;
      end
      if (acc && !ovf) begin q_bx[q_n] = m_bx; q_ev[q_n] = m_ev[EV_W-1:0]; q_n++; end
      err = mism || ovf;
      if (eclr) begin m_flag = 1'b0; m_cnt = '0; end                 // R9
      if (err) begin m_flag = 1'b1; if (!(&m_cnt)) m_cnt = m_cnt + 1'b1; end   // R10
      if (rb) m_bx = '0; else if (m_bx == last) m_bx = '0; else m_bx = m_bx + 1'b1;  // R1
      if (re) m_ev = '0; else if (acc) m_ev = m_ev + 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk("R5 tag_valid", 32'(tag_valid), 32'(m_tv));
    chk("R1 R2 R5 tag_bx", 32'(tag_bx), 32'(m_tbx));
    chk("R3 R4 tag_ev_ext", tag_ext, m_tev);
    chk("R6 tag_ev", 32'(tag_ev), 32'(m_tev[EV_W-1:0]));
    chk("R7 R8 R9 err_flag", 32'(err_flag), 32'(m_flag));
    chk("R10 err_count", 32'(err_cnt), 32'(m_cnt));
  endtask

  task automatic drive();
    acc  = ($urandom % 100) < p_acc;
    bcr  = (bcr_per != 0) && (cyc % bcr_per == 0);
    evr  = (evr_per != 0) && (($urandom % evr_per) == 0);
    eclr = ($urandom % 1000) < p_clr;
    fv   = ($urandom % 100) < p_frag;
    if (q_n > 0) begin fbx = q_bx[0]; fev = q_ev[0]; end
    else begin fbx = BX_W'($urandom); fev = EV_W'($urandom); end
    if (fv && (($urandom % 100) < p_bad)) fbx = fbx ^ BX_W'(1 << ($urandom % BX_W));
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      check_outputs();
      cyc++;
      drive();
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; bcr = 0; evr = 0; acc = 1'b1; fv = 1'b1; eclr = 0;
    bdly = '0; edly = '0; last = 12'd3563; fbx = '1; fev = '1;
    repeat (3) @(negedge clk);
    // R11: outputs zero while in reset even with active inputs
    chk("R11 tag_valid", 32'(tag_valid), 0);
    chk("R11 tag_bx", 32'(tag_bx), 0);
    chk("R11 tag_ext", tag_ext, 0);
    chk("R11 err_flag", 32'(err_flag), 0);
    chk("R11 err_count", 32'(err_cnt), 0);
    acc = 0; fv = 0;
    @(negedge clk);
    rst_n = 1'b1;

    // R1: default period with no reset, so the 3563 wrap occurs
    p_acc = 4; p_frag = 4;
    run(3700);

    // R1 R2: short period with bunch reset at several delays
    last = 12'd99; bcr_per = 100; p_acc = 20; p_frag = 20; p_bad = 5;
    bdly = 8'd0;   run(500);
    bdly = 8'd7;   run(500);
    bdly = 8'd255; run(800);
    bdly = 8'd1;   run(300);

    // R3 R4 R6: event resets at several delays, event number wraps
    evr_per = 40;
    edly = 8'd0;   run(400);
    edly = 8'd13;  run(400);
    edly = 8'd255; run(700);
    evr_per = 0;

    // R8: accept burst with no fragments, then drain
    p_acc = 70; p_frag = 0; p_bad = 0; run(60);
    p_acc = 0; p_frag = 60; run(60);

    // R9: directed clear with no error pending
    @(negedge clk); check_outputs(); cyc++;
    acc = 0; fv = 0; bcr = 0; evr = 0; eclr = 1;
    @(negedge clk); check_outputs(); cyc++;
    eclr = 0;
    run(5);
    // R9: clear and error in the same cycle (fragment with empty queue)
    @(negedge clk); check_outputs(); cyc++;
    acc = 0; bcr = 0; eclr = 1; fv = 1; fbx = '0; fev = '0;
    run(3);

    // R10: many mismatches, counter saturates
    p_acc = 30; p_frag = 50; p_bad = 100; p_clr = 0;
    run(300);

    // mixed random traffic with changing delays
    p_bad = 3; p_clr = 3; evr_per = 300;
    for (int s = 0; s < 10; s++) begin
      bdly = DLY_W'($urandom); edly = DLY_W'($urandom);
      p_acc = 5 + int'($urandom % 40); p_frag = p_acc;
      run(500);
    end

    @(negedge clk); check_outputs();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule